// File: doc/BRIEF.md
# Elastic Three-Stage Arithmetic Pipeline

This block pushes 16-bit words through three fixed arithmetic steps: increment, double, then XOR with a constant key. Each step is joined to the next by a small queue instead of a plain pipeline register. A word enters through a valid/ready handshake into an entry queue. Each stage takes the word at the head of its source queue, transforms it in combinational logic, and places the result in the next queue. The last stage fills an exit queue, which presents results through a valid/ready handshake.

No valid tag travels with the data. Whether a slot holds a live word depends only on the occupancy of the queues. Each stage moves on its own whenever its source has a word and its destination can take one.

The inter-stage queues follow a pipeline ordering. Head read comes first, then dequeue, then enqueue. A full queue therefore accepts a new word in the same cycle that its head leaves, so all stages can advance together. A synchronous flush empties every queue in one cycle.

Top module: `epipe_top`

## Requirements
- R1: Every output word equals ((x + 1) * 2) XOR 16'hA5C3, computed modulo 2^16 at each step, where x is the corresponding input word. Input 16'h0000 gives 16'hA5C1, and both 16'hFFFF and 16'h7FFF give 16'hA5C3.
- R2: Output words leave in the order their inputs were accepted, for any pattern of in_valid and out_ready, with no word lost or repeated.
- R3: When all queues are empty and out_ready is high, a word accepted at a rising edge is presented on out_valid/out_data four cycles later.
- R4: With in_valid and out_ready held high, one result leaves per cycle. Whenever the entry queue and both inter-stage queues hold data and the exit queue can take a word, all three stages advance in the same cycle.
- R5: A full queue accepts a word in the cycle its head is removed. When every queue is full and out_ready is high, in_ready is high in that same cycle.
- R6: With out_ready low, the block accepts exactly 4*DEPTH words (8 with the default DEPTH of 2) and then drops in_ready. While out_ready is low, out_valid stays high and out_data does not change.
- R7: When the middle and last stages have data in their source queues and room in their destinations, both advance in that cycle, even if the entry queue is empty. Stored words therefore drain one per cycle.
- R8: A cycle with flush high leaves every queue empty afterwards: out_valid is low and in_ready is high. A word offered in the flush cycle is discarded. Words accepted afterwards flow normally.
- R9: The synchronous active-high reset leaves the block empty, with out_valid low and in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all queues |
| in_valid | input | 1 | Input word offered |
| in_data | input | 16 | Input word |
| in_ready | output | 1 | Entry queue can take a word |
| out_valid | output | 1 | Result available |
| out_data | output | 16 | Result word |
| out_ready | input | 1 | Consumer takes the result |

## Verification
A table of words that includes the wrap-around values is streamed with the output always ready. This checks the arithmetic, the four-cycle fill latency and the one-result-per-cycle rate that only simultaneous firing of all stages can give.

A backpressure run holds out_ready low until the block is full. It then checks the exact capacity, and checks that in_ready comes back in the same cycle out_ready rises, which separates pipeline-ordered queues from ones that must first empty. The drain that follows must be back-to-back, which shows the later stages advance without new input.

A pseudo-random mix of input gaps and output stalls exercises ordering. Flush tests check the emptying, the discarding of a word offered during the flush, and clean flow afterwards.

// File: rtl/epipe_pkg.sv
package epipe_pkg;

    localparam int DATA_W   = 16;
    localparam int N_STAGES = 3;
    localparam int N_QUEUES = N_STAGES + 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_INC = 2'd0,
        OP_DBL = 2'd1,
        OP_XOR = 2'd2
    } stage_op_e;

    localparam word_t MIX_KEY = 16'hA5C3;

    // Operation assigned to each stage position
    function automatic stage_op_e op_of(input int idx);
        case (idx)
            0:       return OP_INC;
            1:       return OP_DBL;
            default: return OP_XOR;
        endcase
    endfunction

    function automatic word_t apply_op(input stage_op_e op, input word_t x, input word_t key);
        case (op)
            OP_INC:  return x + word_t'(1);
            OP_DBL:  return {x[DATA_W-2:0], 1'b0};
            default: return x ^ key;
        endcase
    endfunction

endpackage

// File: rtl/epipe_queue.sv
module epipe_queue
    import epipe_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  enq_valid,
    input  word_t enq_data,
    output logic  enq_ready,
    output logic  deq_valid,
    output word_t deq_data,
    input  logic  deq_ready
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    word_t          mem [DEPTH];
    logic [AW-1:0]  rd_ptr;
    logic [AW-1:0]  wr_ptr;
    logic [CW-1:0]  count;
    logic           do_enq;
    logic           do_deq;

    assign deq_valid = (count != '0);
    assign deq_data  = mem[rd_ptr];
    // Pipeline ordering: a departing head frees a slot in the same cycle
    assign enq_ready = (count != FULL_CNT) || deq_ready;
    assign do_deq    = deq_valid && deq_ready;
    assign do_enq    = enq_valid && enq_ready;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_enq) begin
                mem[wr_ptr] <= enq_data;
                wr_ptr      <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + AW'(1);
            end
            if (do_deq) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + AW'(1);
            end
            case ({do_enq, do_deq})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/epipe_stage.sv
module epipe_stage
    import epipe_pkg::*;
#(
    parameter stage_op_e OP  = OP_INC,
    parameter word_t     KEY = MIX_KEY
) (
    input  logic  src_valid,
    input  word_t src_data,
    output logic  src_take,
    input  logic  dst_ready,
    output logic  dst_push,
    output word_t dst_data
);
    logic fire;

    assign fire     = src_valid && dst_ready;
    assign src_take = fire;
    assign dst_push = fire;
    assign dst_data = apply_op(OP, src_data, KEY);

endmodule

// File: rtl/epipe_top.sv
module epipe_top
    import epipe_pkg::*;
#(
    parameter int    DEPTH = 2,
    parameter word_t KEY   = MIX_KEY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    logic  enq_v [N_QUEUES];
    logic  enq_r [N_QUEUES];
    word_t enq_d [N_QUEUES];
    logic  deq_v [N_QUEUES];
    logic  deq_r [N_QUEUES];
    word_t deq_d [N_QUEUES];

    logic [N_STAGES-1:0] stage_fire;
    logic [N_QUEUES-1:0] q_vld;
    logic [N_QUEUES-1:0] q_rdy;

    assign enq_v[0] = in_valid;
    assign enq_d[0] = in_data;
    assign in_ready = enq_r[0];

    assign out_valid           = deq_v[N_QUEUES-1];
    assign out_data            = deq_d[N_QUEUES-1];
    assign deq_r[N_QUEUES-1]   = out_ready;

    for (genvar q = 0; q < N_QUEUES; q++) begin : g_q
        epipe_queue #(.DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .enq_valid (enq_v[q]),
            .enq_data  (enq_d[q]),
            .enq_ready (enq_r[q]),
            .deq_valid (deq_v[q]),
            .deq_data  (deq_d[q]),
            .deq_ready (deq_r[q])
        );
        assign q_vld[q] = deq_v[q];
        assign q_rdy[q] = enq_r[q];
    end

    for (genvar s = 0; s < N_STAGES; s++) begin : g_s
        epipe_stage #(.OP(op_of(s)), .KEY(KEY)) u_s (
            .src_valid (deq_v[s]),
            .src_data  (deq_d[s]),
            .src_take  (deq_r[s]),
            .dst_ready (enq_r[s+1]),
            .dst_push  (enq_v[s+1]),
            .dst_data  (enq_d[s+1])
        );
        assign stage_fire[s] = deq_r[s];
    end

endmodule

// File: rtl/epipe_chk.sv
module epipe_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        in_ready,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        out_ready,
    input logic [2:0]  fire,
    input logic [3:0]  q_vld,
    input logic [3:0]  q_rdy
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && in_ready)); // R9

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!out_valid && in_ready)); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data))); // R6

    AST_ALL_FIRE: assert property (@(posedge clk) disable iff (rst)
        (q_vld[0] && q_vld[1] && q_vld[2] && q_rdy[3]) |-> (fire == 3'b111)); // R4

    AST_PIPE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (q_vld[0] && fire[1]) |-> fire[0]); // R5

    AST_DRAIN_FIRE: assert property (@(posedge clk) disable iff (rst)
        (q_vld[1] && q_vld[2] && q_rdy[3]) |-> (fire[1] && fire[2])); // R7

endmodule

bind epipe_top epipe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .fire      (stage_fire),
    .q_vld     (q_vld),
    .q_rdy     (q_rdy)
);

// File: tb/epipe_top_tb_top.sv
`timescale 1ns/1ps
module epipe_top_tb_top;

    localparam logic [15:0] KEY = 16'hA5C3;
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        16'h0000, 16'hFFFF, 16'h7FFF, 16'h0001, 16'h1234, 16'h8000, 16'hA5C3, 16'h00FF,
        16'hFF00, 16'h5555, 16'hAAAA, 16'h7FFE, 16'h0F0F, 16'hC001, 16'h3C3C, 16'hFFFE
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;

    epipe_top dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int cyc = 0;

    logic [15:0] src_mem [64];
    int src_len = 0;
    int src_idx = 0;
    bit src_en = 1'b0;

    logic [15:0] exp_q [1024];
    int head = 0;
    int tail = 0;
    logic [15:0] out_log [64];
    int n_out = 0;
    int n_acc = 0;
    int first_acc = -1;
    int first_out = -1;
    int last_out = -1;
    int max_gap = 0;

    function automatic logic [15:0] ref_fn(input logic [15:0] x);
        logic [15:0] t;
        t = x + 16'd1;
        t = t << 1;
        return t ^ KEY;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic clear_stats();
        n_out = 0; n_acc = 0; first_acc = -1; first_out = -1;
        last_out = -1; max_gap = 0;
    endtask

    task automatic load_src(input int n, input int base, input int step);
        for (int i = 0; i < n; i++) src_mem[i] = 16'(base + i * step);
        src_len = n;
        src_idx = 0;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: applies source words shortly after the falling edge
    always @(negedge clk) begin
        #1;
        in_valid = src_en && (src_idx < src_len);
        in_data  = (src_idx < src_len) ? src_mem[src_idx] : 16'h0;
    end

    // Monitor: samples handshakes that will complete at the next rising edge
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (in_valid && in_ready) begin
                src_idx++;
                if (!flush) begin
                    exp_q[tail % 1024] = in_data;
                    tail++;
                    if (first_acc < 0) first_acc = cyc;
                    n_acc++;
                end
            end
            if (out_valid && out_ready && !flush) begin
                if (head == tail) begin
                    chk(1'b0, "R2", "unexpected extra output", out_data, 0);
                end else begin
                    chk(out_data == ref_fn(exp_q[head % 1024]), "R2",
                        "output value/order", out_data, ref_fn(exp_q[head % 1024]));
                    head++;
                end
                if (n_out < 64) out_log[n_out] = out_data;
                if (first_out < 0) first_out = cyc;
                if (last_out >= 0 && (cyc - last_out) > max_gap) max_gap = cyc - last_out;
                last_out = cyc;
                n_out++;
            end
            if (flush) head = tail;
        end
    end

    task automatic wait_out(input int n, input int limit);
        for (int i = 0; i < limit && n_out < n; i++) @(negedge clk);
        #3;
    endtask

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

        // Table stream, output always ready
        for (int i = 0; i < NV; i++) src_mem[i] = VEC[i];
        src_len = NV; src_idx = 0;
        clear_stats();
        @(negedge clk);
        out_ready = 1'b1;
        src_en = 1'b1;
        wait_out(NV, 60);
        chk(n_out == NV, "R2", "table output count", n_out, NV);
        chk(out_log[0] == 16'hA5C1, "R1", "f(0000)", out_log[0], 16'hA5C1);
        chk(out_log[1] == 16'hA5C3, "R1", "f(FFFF)", out_log[1], 16'hA5C3);
        chk(out_log[2] == 16'hA5C3, "R1", "f(7FFF)", out_log[2], 16'hA5C3);
        chk(first_out - first_acc == 4, "R3", "fill latency", first_out - first_acc, 4);
        chk(last_out - first_out == NV - 1, "R4", "stream span", last_out - first_out, NV - 1);
        @(negedge clk);
        src_en = 1'b0;

        // Backpressure: fill, then release
        load_src(12, 5, 37);
        clear_stats();
        @(negedge clk);
        out_ready = 1'b0;
        src_en = 1'b1;
        repeat (20) @(negedge clk);
        #3;
        chk(n_acc == 8, "R6", "words accepted while stalled", n_acc, 8);
        chk(in_ready == 1'b0, "R6", "in_ready when full", in_ready, 0);
        chk(out_valid == 1'b1, "R6", "out_valid while stalled", out_valid, 1);
        @(negedge clk);
        out_ready = 1'b1;
        #3;
        chk(in_ready == 1'b1, "R5", "in_ready when full and out_ready", in_ready, 1);
        wait_out(12, 60);
        chk(n_out == 12, "R2", "backpressure output count", n_out, 12);
        chk(max_gap == 1, "R7", "drain gap", max_gap, 1);
        @(negedge clk);
        src_en = 1'b0;

        // Pseudo-random stalls and gaps
        load_src(40, 16'h0100, 16'h0123);
        clear_stats();
        lf = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            out_ready = lf[0];
            src_en = lf[3] | lf[5];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end
        @(negedge clk);
        out_ready = 1'b1;
        src_en = 1'b1;
        wait_out(40, 200);
        chk(n_out == 40, "R2", "random output count", n_out, 40);
        chk(head == tail, "R2", "scoreboard empty", tail - head, 0);
        @(negedge clk);
        src_en = 1'b0;

        // Flush with stored words
        load_src(5, 16'h2000, 3);
        clear_stats();
        @(negedge clk);
        out_ready = 1'b0;
        src_en = 1'b1;
        repeat (10) @(negedge clk);
        src_en = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        #3;
        chk(out_valid == 1'b0, "R8", "out_valid after flush", out_valid, 0);
        chk(in_ready == 1'b1, "R8", "in_ready after flush", in_ready, 1);

        // Word offered during flush is discarded
        load_src(1, 16'h1234, 0);
        clear_stats();
        @(negedge clk);
        src_en = 1'b1;
        flush = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        src_en = 1'b0;
        repeat (8) @(negedge clk);
        #3;
        chk(n_out == 0, "R8", "output from word offered in flush", n_out, 0);

        // Flow resumes after flush
        load_src(1, 16'h0042, 0);
        clear_stats();
        @(negedge clk);
        src_en = 1'b1;
        wait_out(1, 20);
        chk(n_out == 1, "R8", "output count after flush", n_out, 1);
        chk(out_log[0] == ref_fn(16'h0042), "R8", "value after flush",
            out_log[0], ref_fn(16'h0042));
        @(negedge clk);
        src_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule